// File: doc/BRIEF.md
# Non-Volatile Setting Program Controller

This block decides when the present 7-bit adjustment setting is committed to non-volatile storage. Programming is requested on the same pin that carries the count pulses: the pin is driven above a high-voltage threshold, and a comparator, synchronized upstream, reports this on `hvFlag`. The request only counts once the flag has stayed high without a break for longer than a dwell time. Once accepted, the block issues a one-cycle write strobe with the captured setting. It then holds `busy` for the full fixed write time.

The block also asks the step counter to reload the stored value. This happens once after reset is released (power-up) and again each time `enable` falls. While the over-voltage level is present or a write is running, the block raises `countInhibit` so the step counter ignores the pin. The dwell and write times are parameters in clock ticks. At a 200 MHz clock the defaults give 200 µs and 100 ms.

Top module: `nvProgCtrl`

## Requirements
- R1: A write starts only after `hvFlag` has been sampled high on more than `DWELL_TICKS` consecutive rising clock edges (`DWELL_TICKS`+1 samples) with `enable` high. A run of exactly `DWELL_TICKS` high samples starts no write.
- R2: Each accepted request produces `wrStrobe` high for exactly one clock cycle. `busy` rises in that same cycle.
- R3: `busy` stays high for exactly `WRITE_TICKS` clock cycles per write.
- R4: `wrData` carries the value of `setting` sampled at the clock edge that accepts the request. It keeps that value while later changes of `setting` happen.
- R5: While `enable` is low, no request is accepted, however long `hvFlag` is held high.
- R6: `reload` pulses high for one cycle on the first clock edge after reset is released. It also pulses for one cycle on the edge after each falling edge of `enable`. It is low otherwise.
- R7: Requests seen during `busy` are ignored. After a write, a new request is accepted only once `hvFlag` has been sampled low at least once and then held high again for the dwell time.
- R8: `countInhibit` is high in every cycle where `hvFlag` or `busy` is high.
- R9: In reset, `busy`, `wrStrobe` and `reload` are low and `wrData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset (power-up) |
| enable | input | 1 | Adjustment enable; low blocks programming, falling edge requests reload |
| hvFlag | input | 1 | Synchronized over-voltage comparator output |
| setting | input | 7 | Current counter setting |
| wrStrobe | output | 1 | One-cycle write strobe to storage |
| wrData | output | 7 | Setting captured for the write |
| busy | output | 1 | High for the whole write window |
| reload | output | 1 | One-cycle request to load stored value into the counter |
| countInhibit | output | 1 | Tells the step counter to ignore the control pin |

## Verification
The hardest situation to reach is the re-arm rule: a request that arrives while a write is in progress must be ignored. A flag that never drops across and beyond a write must not start a second one. The bench holds `hvFlag` high for longer than dwell plus write time and checks that exactly one write happened. It then drops the flag for a single cycle and re-requests, which must give a second write. A separate scenario releases and re-asserts the flag inside the busy window. The boundary at exactly `DWELL_TICKS` versus `DWELL_TICKS`+1 samples is driven directly.

// File: rtl/nvProgPkg.sv
package nvProgPkg;
  localparam int SETTING_W = 7;

  typedef struct packed {
    logic startWrite;
    logic endWrite;
  } ctrlStrobes_t;
endpackage

// File: rtl/nvProgCtrl_fsm.sv
module nvProgCtrl_fsm
  import nvProgPkg::*;
#(
  parameter int DWELL_TICKS = 40000,
  parameter int WRITE_TICKS = 20000000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         hvFlag,
  output ctrlStrobes_t strobes
);
  localparam int DW = $clog2(DWELL_TICKS + 1);
  localparam int WW = $clog2(WRITE_TICKS);
  localparam logic [DW-1:0] DWELL_LAST = DW'(DWELL_TICKS);
  localparam logic [WW-1:0] WRITE_LAST = WW'(WRITE_TICKS - 1);

  typedef enum logic {ST_IDLE, ST_WRITING} state_t;

  state_t        state;
  logic          armed;
  logic [DW-1:0] dwellCnt;
  logic [WW-1:0] writeCnt;
  logic          qualifying;

  assign qualifying = (state == ST_IDLE) && enable && hvFlag && armed;

  always_comb begin
    strobes.startWrite = qualifying && (dwellCnt == DWELL_LAST);
    strobes.endWrite   = (state == ST_WRITING) && (writeCnt == WRITE_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      armed    <= 1'b0;
      dwellCnt <= '0;
      writeCnt <= '0;
    end else begin
      if (!hvFlag)                 armed <= 1'b1;
      else if (strobes.startWrite) armed <= 1'b0;

      if (qualifying && !strobes.startWrite) dwellCnt <= dwellCnt + 1'b1;
      else                                   dwellCnt <= '0;

      case (state)
        ST_IDLE: begin
          writeCnt <= '0;
          if (strobes.startWrite) state <= ST_WRITING;
        end
        ST_WRITING: begin
          writeCnt <= writeCnt + 1'b1;
          if (strobes.endWrite) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nvProgCtrl_dp.sv
module nvProgCtrl_dp
  import nvProgPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic [SETTING_W-1:0] setting,
  input  ctrlStrobes_t         strobes,
  output logic                 wrStrobe,
  output logic [SETTING_W-1:0] wrData,
  output logic                 busy,
  output logic                 reload
);
  logic bootPend;
  logic enPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      wrData   <= '0;
      busy     <= 1'b0;
      reload   <= 1'b0;
      bootPend <= 1'b1;
      enPrev   <= 1'b0;
    end else begin
      wrStrobe <= strobes.startWrite;
      if (strobes.startWrite) wrData <= setting;
      if (strobes.startWrite)    busy <= 1'b1;
      else if (strobes.endWrite) busy <= 1'b0;
      reload   <= bootPend || (enPrev && !enable);
      bootPend <= 1'b0;
      enPrev   <= enable;
    end
  end
endmodule

// File: rtl/nvProgCtrl.sv
module nvProgCtrl
  import nvProgPkg::*;
#(
  parameter int DWELL_TICKS = 40000,
  parameter int WRITE_TICKS = 20000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       hvFlag,
  input  logic [6:0] setting,
  output logic       wrStrobe,
  output logic [6:0] wrData,
  output logic       busy,
  output logic       reload,
  output logic       countInhibit
);
  ctrlStrobes_t strobes;

  nvProgCtrl_fsm #(.DWELL_TICKS(DWELL_TICKS), .WRITE_TICKS(WRITE_TICKS)) uFsm (
    .clk(clk), .rstN(rstN), .enable(enable), .hvFlag(hvFlag), .strobes(strobes)
  );

  nvProgCtrl_dp uDp (
    .clk(clk), .rstN(rstN), .enable(enable), .setting(setting), .strobes(strobes),
    .wrStrobe(wrStrobe), .wrData(wrData), .busy(busy), .reload(reload)
  );

  assign countInhibit = hvFlag | busy;
endmodule

// File: rtl/nvProgCtrl_chk.sv
module nvProgCtrl_chk #(
  parameter int DWELL_TICKS = 40000,
  parameter int WRITE_TICKS = 20000000
) (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       hvFlag,
  input logic [6:0] setting,
  input logic       wrStrobe,
  input logic [6:0] wrData,
  input logic       busy,
  input logic       reload,
  input logic       countInhibit
);
  int unsigned hvRun;
  int unsigned busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hvRun   <= 0;
      busyRun <= 0;
    end else begin
      hvRun   <= hvFlag ? ((hvRun > DWELL_TICKS) ? hvRun : hvRun + 1) : 0;
      busyRun <= busy ? busyRun + 1 : 0;
    end
  end

  p_dwell_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(hvFlag) && $past(hvRun) >= DWELL_TICKS));
  p_strobe_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> wrStrobe);
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);
  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == WRITE_TICKS));
  p_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (wrData == $past(setting)));
  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !wrStrobe) |-> $stable(wrData));
  p_enable_block_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(enable));
  p_reload_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enable) |=> reload);
  p_reload_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    reload |=> !reload);
  p_inhibit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hvFlag || busy) |-> countInhibit);
  always_comb begin
    if (!rstN) begin
      a_reset_r9: assert (!busy && !wrStrobe && !reload && wrData == 7'd0);
    end
  end
endmodule

bind nvProgCtrl nvProgCtrl_chk #(.DWELL_TICKS(DWELL_TICKS), .WRITE_TICKS(WRITE_TICKS)) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .hvFlag(hvFlag), .setting(setting),
  .wrStrobe(wrStrobe), .wrData(wrData), .busy(busy), .reload(reload),
  .countInhibit(countInhibit)
);

// File: tb/tb_nvProgCtrl.sv
`timescale 1ns/1ps
module tb_nvProgCtrl;
  localparam int D = 8;
  localparam int W = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1;
  logic hvFlag = 1'b0;
  logic [6:0] setting = 7'd0;
  logic wrStrobe, busy, reload, countInhibit;
  logic [6:0] wrData;

  int checks = 0;
  int fails = 0;
  int writes = 0;
  int strobeCycles = 0;
  int reloads = 0;
  int busyRun = 0;
  int lastRun = 0;
  logic [6:0] stored = 7'd0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nvProgCtrl #(.DWELL_TICKS(D), .WRITE_TICKS(W)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .hvFlag(hvFlag), .setting(setting),
    .wrStrobe(wrStrobe), .wrData(wrData), .busy(busy), .reload(reload),
    .countInhibit(countInhibit)
  );

  always @(posedge clk) begin
    if (rstN && wrStrobe) begin
      stored = wrData;
      writes++;
      strobeCycles++;
    end
    if (rstN && reload) reloads++;
  end

  always @(negedge clk) begin
    if (busy) busyRun++;
    else if (busyRun != 0) begin
      lastRun = busyRun;
      busyRun = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hvHold(input int n);
    @(negedge clk);
    hvFlag = 1'b1;
    repeat (n) @(negedge clk);
    hvFlag = 1'b0;
  endtask

  task automatic t_reset();
    check(busy == 0 && wrStrobe == 0 && reload == 0 && wrData == 0, "R9",
          {busy, wrStrobe, reload, wrData}, 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(reloads == 1, "R6", reloads, 1);
    check(busy == 0 && writes == 0, "R9", writes, 0);
  endtask

  task automatic t_short_dwell();
    int w0 = writes;
    setting = 7'h11;
    @(negedge clk);
    hvFlag = 1'b1;
    repeat (D / 2) @(negedge clk);
    check(countInhibit == 1, "R8", countInhibit, 1);
    repeat (D - D / 2) @(negedge clk);
    hvFlag = 1'b0;
    repeat (4) @(negedge clk);
    check(writes == w0 && busy == 0, "R1", writes - w0, 0);
  endtask

  task automatic t_program();
    int w0 = writes;
    setting = 7'h55;
    hvHold(D + 1);
    setting = 7'h0F;
    repeat (W + 5) @(negedge clk);
    check(writes == w0 + 1, "R1", writes - w0, 1);
    check(strobeCycles == writes, "R2", strobeCycles, writes);
    check(stored == 7'h55, "R4", stored, 7'h55);
    check(lastRun == W, "R3", lastRun, W);
  endtask

  task automatic t_enable_low();
    int w0 = writes;
    int r0 = reloads;
    @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    check(reloads == r0 + 1, "R6", reloads - r0, 1);
    hvHold(D + 10);
    repeat (W) @(negedge clk);
    check(writes == w0 && busy == 0, "R5", writes - w0, 0);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    check(reloads == r0 + 1, "R6", reloads - r0, 1);
  endtask

  task automatic t_rearm();
    int w0 = writes;
    setting = 7'h2A;
    @(negedge clk);
    hvFlag = 1'b1;
    repeat (D + 3) @(negedge clk);
    setting = 7'h7F;
    repeat (W + 2 * D + 10) @(negedge clk);
    check(writes == w0 + 1, "R7", writes - w0, 1);
    check(stored == 7'h2A, "R4", stored, 7'h2A);
    hvFlag = 1'b0;
    hvHold(D + 1);
    repeat (W + 5) @(negedge clk);
    check(writes == w0 + 2, "R7", writes - w0, 2);
    check(stored == 7'h7F, "R4", stored, 7'h7F);
  endtask

  task automatic t_during_busy();
    int w0 = writes;
    setting = 7'h03;
    hvHold(D + 1);
    check(busy == 1, "R2", busy, 1);
    @(negedge clk);
    check(busy == 1 && hvFlag == 0 && countInhibit == 1, "R8", countInhibit, 1);
    hvHold(D + 1);
    repeat (W + 10) @(negedge clk);
    check(writes == w0 + 1, "R7", writes - w0, 1);
    check(stored == 7'h03 && lastRun == W, "R3", lastRun, W);
  endtask

  initial begin
    t_reset();
    t_short_dwell();
    t_program();
    t_enable_low();
    t_rearm();
    t_during_busy();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule